// File: doc/BRIEF.md
# Multiplexed Bus-Exchange Latch Array

This block connects one data port, A, with two bank ports, B1 and B2, through four independently enabled storage latches. Toward A, each bank has its own latch and a select input picks which of the two held words appears on A. Toward the banks, A feeds two separate latches, so a sequence of A words can be split across the banks. A typical use is interleaving, or separating, address and data words that share a single bus.

Every port is a pair of unidirectional buses plus a drive flag. The flag is the inverse of that port's active-low output enable, and it is forced off during reset. Latches are modelled on the system clock. While a latch enable is high, the latch output follows its input in the same cycle. The stored word is the input sampled at the last rising clock edge with the enable high, and it is held until the enable rises again. A synchronous reset clears all four stored words and disables all three drivers.

Top module: `bus_exchange_latch`

## Requirements
- R1: While `rst` is high, `aDrive`, `b1Drive` and `b2Drive` are 0. A reset edge clears all four stored words to 0, so a closed latch reads 0 after reset.
- R2: While a latch enable is high and `rst` is low, that latch output equals its input in the same cycle. This holds for B1 to A, B2 to A, A to B1 and A to B2.
- R3: After a latch enable falls, the latch output holds the input that was sampled at the last clock edge with the enable high. Later input changes do not alter it.
- R4: `aOut` shows the B1-side latch output when `sel` is 1 and the B2-side latch output when `sel` is 0.
- R5: Outside reset, `aDrive` equals the inverse of `aOeN`.
- R6: Outside reset, `b1Drive` equals the inverse of `b1OeN` and `b2Drive` equals the inverse of `b2OeN`. The two are independent, so all four combinations occur.
- R7: The A-to-B1 and A-to-B2 latches capture independently, so two successive A words with staggered enables end up in different banks.
- R8: Every output bus presents its latched or selected data whether or not its drive flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| aIn | input | WIDTH | Word arriving on port A |
| aOut | output | WIDTH | Word presented on port A |
| aDrive | output | 1 | Port A driver active |
| b1In | input | WIDTH | Word arriving on bank 1 |
| b1Out | output | WIDTH | Word presented on bank 1 |
| b1Drive | output | 1 | Bank 1 driver active |
| b2In | input | WIDTH | Word arriving on bank 2 |
| b2Out | output | WIDTH | Word presented on bank 2 |
| b2Drive | output | 1 | Bank 2 driver active |
| aOeN | input | 1 | Port A output enable, active low |
| b1OeN | input | 1 | Bank 1 output enable, active low |
| b2OeN | input | 1 | Bank 2 output enable, active low |
| sel | input | 1 | 1 routes the B1 latch to A, 0 routes the B2 latch |
| leB1ToA | input | 1 | Enable of the B1-to-A latch |
| leB2ToA | input | 1 | Enable of the B2-to-A latch |
| leAToB1 | input | 1 | Enable of the A-to-B1 latch |
| leAToB2 | input | 1 | Enable of the A-to-B2 latch |

## Verification
The bench builds the block with WIDTH set to 4. At that width it can sweep every pair of distinct words through both bank-to-A latches and through both A-to-bank latches. Each pair is captured, held against inverted inputs, and read back under both select values. At every step, all three output buses and drive flags are compared against an arithmetic model of the four latches. All eight output-enable combinations are also crossed with open and closed latches.

// File: rtl/bx_pkg.sv
package bx_pkg;

  localparam int NUM_SLOTS = 4;

  // slot order: the A-side mux reads slots 0 and 1
  localparam int SLOT_B1_TO_A = 0;
  localparam int SLOT_B2_TO_A = 1;
  localparam int SLOT_A_TO_B1 = 2;
  localparam int SLOT_A_TO_B2 = 3;

  typedef struct packed {
    logic                 clear;
    logic [NUM_SLOTS-1:0] open;
    logic                 pickBank1;
    logic                 drvA;
    logic                 drvB1;
    logic                 drvB2;
  } bxStrobes_t;

endpackage

// File: rtl/bx_latch_slice.sv
module bx_latch_slice #(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             open,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] qOut
);

  logic [WIDTH-1:0] held;

  // the stored word follows the input on every edge the latch is open
  always_ff @(posedge clk) begin
    if (clear) begin
      held <= '0;
    end else if (open) begin
      held <= dIn;
    end
  end

  // transparent path while open, stored word otherwise
  always_comb begin
    if (open) begin
      qOut = dIn;
    end else begin
      qOut = held;
    end
  end

endmodule

// File: rtl/bx_control.sv
module bx_control
  import bx_pkg::*;
(
  input  logic       rst,
  input  logic       sel,
  input  logic       leB1ToA,
  input  logic       leB2ToA,
  input  logic       leAToB1,
  input  logic       leAToB2,
  input  logic       aOeN,
  input  logic       b1OeN,
  input  logic       b2OeN,
  output bxStrobes_t strobes
);

  logic [NUM_SLOTS-1:0] rawEnables;

  always_comb begin
    rawEnables               = '0;
    rawEnables[SLOT_B1_TO_A] = leB1ToA;
    rawEnables[SLOT_B2_TO_A] = leB2ToA;
    rawEnables[SLOT_A_TO_B1] = leAToB1;
    rawEnables[SLOT_A_TO_B2] = leAToB2;
  end

  always_comb begin
    strobes.clear     = rst;
    strobes.open      = rst ? '0 : rawEnables;
    strobes.pickBank1 = sel;
    strobes.drvA      = ~rst & ~aOeN;
    strobes.drvB1     = ~rst & ~b1OeN;
    strobes.drvB2     = ~rst & ~b2OeN;
  end

endmodule

// File: rtl/bx_datapath.sv
module bx_datapath
  import bx_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  bxStrobes_t       strobes,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] b1In,
  input  logic [WIDTH-1:0] b2In,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] b1Out,
  output logic [WIDTH-1:0] b2Out
);

  logic [WIDTH-1:0] slotIn  [NUM_SLOTS];
  logic [WIDTH-1:0] slotOut [NUM_SLOTS];

  always_comb begin
    slotIn[SLOT_B1_TO_A] = b1In;
    slotIn[SLOT_B2_TO_A] = b2In;
    slotIn[SLOT_A_TO_B1] = aIn;
    slotIn[SLOT_A_TO_B2] = aIn;
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : gSlot
    bx_latch_slice #(.WIDTH(WIDTH)) u_slice (
      .clk   (clk),
      .clear (strobes.clear),
      .open  (strobes.open[g]),
      .dIn   (slotIn[g]),
      .qOut  (slotOut[g])
    );
  end

  always_comb begin
    aOut  = strobes.pickBank1 ? slotOut[SLOT_B1_TO_A] : slotOut[SLOT_B2_TO_A];
    b1Out = slotOut[SLOT_A_TO_B1];
    b2Out = slotOut[SLOT_A_TO_B2];
  end

endmodule

// File: rtl/bus_exchange_latch.sv
module bus_exchange_latch
  import bx_pkg::*;
#(
  parameter int WIDTH = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aDrive,
  input  logic [WIDTH-1:0] b1In,
  output logic [WIDTH-1:0] b1Out,
  output logic             b1Drive,
  input  logic [WIDTH-1:0] b2In,
  output logic [WIDTH-1:0] b2Out,
  output logic             b2Drive,
  input  logic             aOeN,
  input  logic             b1OeN,
  input  logic             b2OeN,
  input  logic             sel,
  input  logic             leB1ToA,
  input  logic             leB2ToA,
  input  logic             leAToB1,
  input  logic             leAToB2
);

  bxStrobes_t strobes;

  bx_control u_control (
    .rst     (rst),
    .sel     (sel),
    .leB1ToA (leB1ToA),
    .leB2ToA (leB2ToA),
    .leAToB1 (leAToB1),
    .leAToB2 (leAToB2),
    .aOeN    (aOeN),
    .b1OeN   (b1OeN),
    .b2OeN   (b2OeN),
    .strobes (strobes)
  );

  bx_datapath #(.WIDTH(WIDTH)) u_datapath (
    .clk     (clk),
    .strobes (strobes),
    .aIn     (aIn),
    .b1In    (b1In),
    .b2In    (b2In),
    .aOut    (aOut),
    .b1Out   (b1Out),
    .b2Out   (b2Out)
  );

  assign aDrive  = strobes.drvA;
  assign b1Drive = strobes.drvB1;
  assign b2Drive = strobes.drvB2;

endmodule

// File: rtl/bx_checker.sv
module bx_checker #(
  parameter int WIDTH = 12
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] aIn,
  input logic [WIDTH-1:0] aOut,
  input logic             aDrive,
  input logic [WIDTH-1:0] b1In,
  input logic [WIDTH-1:0] b1Out,
  input logic             b1Drive,
  input logic [WIDTH-1:0] b2In,
  input logic [WIDTH-1:0] b2Out,
  input logic             b2Drive,
  input logic             aOeN,
  input logic             b1OeN,
  input logic             b2OeN,
  input logic             sel,
  input logic             leB1ToA,
  input logic             leB2ToA,
  input logic             leAToB1,
  input logic             leAToB2
);

  logic warm = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) warm <= 1'b0;
    else     warm <= 1'b1;
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |-> (!aDrive && !b1Drive && !b2Drive));

  // R2
  open_b1_pass_chk: assert property (@(posedge clk) disable iff (rst)
    leAToB1 |-> (b1Out == aIn));

  // R2
  open_b2_pass_chk: assert property (@(posedge clk) disable iff (rst)
    leAToB2 |-> (b2Out == aIn));

  // R3
  capture_b1_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    $fell(leAToB1) |-> (b1Out == $past(aIn)));

  // R3
  hold_b2_chk: assert property (@(posedge clk) disable iff (rst || !warm)
    (!leAToB2 && $past(!leAToB2)) |-> $stable(b2Out));

  // R4
  pick_bank1_chk: assert property (@(posedge clk) disable iff (rst)
    (sel && leB1ToA) |-> (aOut == b1In));

  // R4
  pick_bank2_chk: assert property (@(posedge clk) disable iff (rst)
    (!sel && leB2ToA) |-> (aOut == b2In));

  // R5
  a_drive_chk: assert property (@(posedge clk) disable iff (rst)
    aDrive == !aOeN);

  // R6
  bank_drive_chk: assert property (@(posedge clk) disable iff (rst)
    (b1Drive == !b1OeN) && (b2Drive == !b2OeN));

endmodule

bind bus_exchange_latch bx_checker #(.WIDTH(WIDTH)) u_bx_checker (.*);

// File: tb/bus_exchange_latch_bench.sv
module bus_exchange_latch_bench;

  localparam int W = 4;
  localparam int N = 1 << W;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst = 1'b1;
  logic [W-1:0] aIn = '0, b1In = '0, b2In = '0;
  logic [W-1:0] aOut, b1Out, b2Out;
  logic aDrive, b1Drive, b2Drive;
  logic aOeN = 1'b1, b1OeN = 1'b1, b2OeN = 1'b1;
  logic sel = 1'b0;
  logic leB1ToA = 1'b0, leB2ToA = 1'b0, leAToB1 = 1'b0, leAToB2 = 1'b0;

  bus_exchange_latch #(.WIDTH(W)) u_bus_exchange_latch (.*);

  int compared = 0;
  int mismatched = 0;
  logic [W-1:0] m1 = '0, m2 = '0, n1 = '0, n2 = '0;

  task automatic check(string tag, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // one clock: model captures what the design samples, then new inputs may be set
  task automatic cyc();
    @(posedge clk);
    if (rst) begin
      m1 = '0; m2 = '0; n1 = '0; n2 = '0;
    end else begin
      if (leB1ToA) m1 = b1In;
      if (leB2ToA) m2 = b2In;
      if (leAToB1) n1 = aIn;
      if (leAToB2) n2 = aIn;
    end
    @(negedge clk);
  endtask

  task automatic compareAll(string tag);
    logic [W-1:0] e1, e2, eA, eB1, eB2;
    #2;
    e1  = (leB1ToA && !rst) ? b1In : m1;
    e2  = (leB2ToA && !rst) ? b2In : m2;
    eA  = sel ? e1 : e2;
    eB1 = (leAToB1 && !rst) ? aIn : n1;
    eB2 = (leAToB2 && !rst) ? aIn : n2;
    check(tag, "aOut", int'(aOut), int'(eA));
    check(tag, "b1Out", int'(b1Out), int'(eB1));
    check(tag, "b2Out", int'(b2Out), int'(eB2));
    check(tag, "aDrive", int'(aDrive), rst ? 0 : int'(!aOeN));
    check(tag, "b1Drive", int'(b1Drive), rst ? 0 : int'(!b1OeN));
    check(tag, "b2Drive", int'(b2Drive), rst ? 0 : int'(!b2OeN));
  endtask

  initial begin
    #(20 * 190000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    @(negedge clk);
    aOeN = 1'b0; b1OeN = 1'b0; b2OeN = 1'b0;
    leB1ToA = 1'b1; leAToB2 = 1'b1; aIn = 4'h9; b1In = 4'h6;
    compareAll("R1");
    cyc(); compareAll("R1");
    cyc(); rst = 1'b0; leB1ToA = 1'b0; leAToB2 = 1'b0;
    compareAll("R1");
    sel = 1'b1; compareAll("R1");

    // R2 R3 R4: both bank-to-A latches, all word pairs
    for (int x = 0; x < N; x++) begin
      for (int y = 0; y < N; y++) begin
        cyc();
        b1In = W'(x); b2In = W'(y); leB1ToA = 1'b1; leB2ToA = 1'b1; sel = y[0];
        compareAll("R2");
        cyc();
        b1In = ~W'(x); b2In = ~W'(y); leB1ToA = 1'b0; leB2ToA = 1'b0; sel = 1'b1;
        compareAll("R3");
        sel = 1'b0; compareAll("R4");
      end
    end

    // R7: demultiplex two A words into the banks with staggered enables
    for (int x = 0; x < N; x++) begin
      for (int y = 0; y < N; y++) begin
        cyc();
        aIn = W'(x); leAToB1 = 1'b1; leAToB2 = 1'b0;
        compareAll("R2");
        cyc();
        aIn = W'(y); leAToB1 = 1'b0; leAToB2 = 1'b1;
        compareAll("R7");
        cyc();
        aIn = W'(x ^ y ^ 5); leAToB2 = 1'b0;
        compareAll("R7");
      end
    end

    // R5 R6 R8: every enable combination, latches open and closed
    for (int k = 0; k < 16; k++) begin
      cyc();
      aOeN = k[0]; b1OeN = k[1]; b2OeN = k[2];
      leB2ToA = k[3]; leAToB1 = k[3]; b2In = W'(k); aIn = W'(15 - k);
      sel = 1'b0;
      compareAll("R5");
      compareAll("R6");
      compareAll("R8");
    end

    // R1: reset in mid-run clears stored words
    cyc();
    leB2ToA = 1'b0; leAToB1 = 1'b0; rst = 1'b1;
    compareAll("R1");
    cyc(); rst = 1'b0;
    compareAll("R1");
    check("R1", "b1Out zero", int'(b1Out), 0);
    check("R1", "b2Out zero", int'(b2Out), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule